// File: doc/BRIEF.md
# Thermal-Aware Workgroup Dispatcher

This block decides which core of a multicore array gets the next workgroup offered by a workgroup queue. It works from a per-core thermal estimate rather than the current reading. For every core it combines three things with four programmable signed fixed-point coefficients: the core's sampled temperature, a neighbour-weighted temperature supplied by the surrounding logic, and the execution time of the pending workgroup on that core. The result is a predicted temperature, clamped to the temperature range and graded as normal, hot or critical.

The pending workgroup goes to the free, non-critical core with the lowest predicted temperature, provided that prediction is normal. When no core qualifies and at least one core is currently critical, the block asks for a one-step frequency reduction instead of granting. Temperatures are captured into a snapshot once per sampling epoch. Execution times and busy flags are used as they arrive.

Top module: `thermal_dispatch`

## Requirements
- R1: After reset, wg_grant and freq_dec are 0, freq_level is FREQ_LEVELS-1, and the coefficients are offset 0, current-temperature weight 1.0, neighbour weight 0 and exec weight 0, so the prediction equals the sampled temperature.
- R2: Coefficients are 12-bit two's-complement with 6 fractional bits. A write with coef_we=1 stores coef_wdata into the coefficient chosen by coef_sel (0 offset, 1 current temperature, 2 neighbour value, 3 exec time) and takes effect from the next cycle. The prediction is floor((ofs + w_cur*T + w_nbr*N + w_exe*E)/64), clamped to 0..255.
- R3: A value above CRIT_LIMIT (80) is critical, a value below HOT_LIMIT (60) is normal, and 60..80 inclusive is hot. Only a core with a normal prediction is eligible.
- R4: The grant goes to the eligible core with the smallest prediction. On equal predictions the lowest index wins.
- R5: A core whose busy bit is set, or whose sampled current temperature is critical, is never granted, whatever its prediction.
- R6: A grant is a one-cycle pulse on wg_grant, with grant_core valid, one cycle after a cycle in which wg_valid=1, wg_grant=0 and an eligible core exists. No evaluation takes place in the cycle where wg_grant is high.
- R7: Core and neighbour temperatures are captured only in the last cycle of each SAMPLE_PERIOD-cycle epoch, counted from reset. Changes between captures do not affect grants or frequency requests.
- R8: When an evaluation finds no eligible core and some sampled current temperature is critical, freq_dec pulses for one cycle and freq_level drops by one in that same cycle. No grant is given.
- R9: When an evaluation finds no eligible core and no sampled current temperature is critical, no grant and no freq_dec are issued; the workgroup waits.
- R10: At most one freq_dec is issued per sampling epoch. The allowance is restored by the capture at the end of the epoch.
- R11: freq_level never goes below 0. At level 0 a failed evaluation produces no freq_dec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient selector: 0 offset, 1 current, 2 neighbour, 3 exec |
| coef_wdata | input | 12 | Signed coefficient value, 6 fractional bits |
| core_temp | input | NUM_CORES*8 | Per-core current temperature, core i at bits [8i+7:8i] |
| nbr_temp | input | NUM_CORES*8 | Per-core neighbour-weighted temperature |
| wg_exec | input | NUM_CORES*8 | Pending workgroup's execution time on each core |
| core_busy | input | NUM_CORES | Core currently unavailable |
| wg_valid | input | 1 | Queue presents a workgroup |
| wg_grant | output | 1 | Workgroup accepted (one-cycle pulse) |
| grant_core | output | clog2(NUM_CORES) | Index of the receiving core |
| freq_dec | output | 1 | One-step frequency reduction request |
| freq_level | output | clog2(FREQ_LEVELS) | Current frequency level |

## Verification
The hardest situation to reach from the ports is a run of failed evaluations under thermal emergency, long enough to use up the frequency levels. Each decrement needs a fresh sampling epoch, so the bench shortens the epoch and holds a request against a snapshot in which every prediction is hot or critical, until the level floor is reached. The classification edges at 59, 60, 80 and 81 are placed on separate cores in one snapshot. The emergency-free wait case uses a snapshot that is uniformly hot. A behavioural reference model runs alongside and is compared on every clock, including through a randomized phase with coefficient rewrites.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;

    parameter int TEMP_W    = 8;
    parameter int EXEC_W    = 8;
    parameter int COEF_W    = 12;
    parameter int COEF_FRAC = 6;

    localparam int ACC_W    = COEF_W + TEMP_W + 4;
    localparam int TEMP_MAX = (1 << TEMP_W) - 1;
    localparam int COEF_ONE = 1 << COEF_FRAC;

    typedef logic [TEMP_W-1:0]        temp_t;
    typedef logic [EXEC_W-1:0]        exec_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        COEF_OFS = 2'd0,
        COEF_CUR = 2'd1,
        COEF_NBR = 2'd2,
        COEF_EXE = 2'd3
    } coef_sel_e;

    typedef struct packed {
        coef_t ofs;
        coef_t cur;
        coef_t nbr;
        coef_t exe;
    } coef_set_t;

    typedef enum logic [1:0] {
        HEAT_NORMAL = 2'd0,
        HEAT_HOT    = 2'd1,
        HEAT_CRIT   = 2'd2
    } heat_e;

    typedef struct packed {
        temp_t pred;
        heat_e pred_heat;
        heat_e cur_heat;
    } core_view_t;

    function automatic heat_e heat_of(temp_t t, temp_t hot_lim, temp_t crit_lim);
        if (t > crit_lim)
            return HEAT_CRIT;
        else if (t < hot_lim)
            return HEAT_NORMAL;
        else
            return HEAT_HOT;
    endfunction

    function automatic temp_t clamp_temp(acc_t v);
        if (v < 0)
            return '0;
        else if (v > acc_t'(TEMP_MAX))
            return temp_t'(TEMP_MAX);
        else
            return v[TEMP_W-1:0];
    endfunction

endpackage

// File: rtl/td_epoch_timer.sv
module td_epoch_timer #(
    parameter int PERIOD = 925
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    // R7: captures are at least two cycles apart
    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/td_coef_bank.sv
module td_coef_bank
    import tdisp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  coef_t       wr_data,
    output coef_set_t   coefs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            coefs.ofs <= '0;
            coefs.cur <= coef_t'(COEF_ONE);
            coefs.nbr <= '0;
            coefs.exe <= '0;
        end else if (wr_en) begin
            case (coef_sel_e'(wr_sel))
                COEF_OFS: coefs.ofs <= wr_data;
                COEF_CUR: coefs.cur <= wr_data;
                COEF_NBR: coefs.nbr <= wr_data;
                default:  coefs.exe <= wr_data;
            endcase
        end
    end

    // R2: an idle write port leaves every coefficient untouched
    a_r2_coef_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(coefs));

endmodule

// File: rtl/td_core_predict.sv
module td_core_predict
    import tdisp_pkg::*;
#(
    parameter int HOT_LIMIT  = 60,
    parameter int CRIT_LIMIT = 80
) (
    input  coef_set_t  coefs,
    input  temp_t      cur_t,
    input  temp_t      nbr_t,
    input  exec_t      exe_t,
    output core_view_t view
);
    localparam temp_t HOT_T  = temp_t'(HOT_LIMIT);
    localparam temp_t CRIT_T = temp_t'(CRIT_LIMIT);

    acc_t term_ofs, term_cur, term_nbr, term_exe;
    acc_t total, scaled;

    always_comb begin
        term_ofs = acc_t'($signed(coefs.ofs));
        term_cur = acc_t'($signed(coefs.cur)) * acc_t'(cur_t);
        term_nbr = acc_t'($signed(coefs.nbr)) * acc_t'(nbr_t);
        term_exe = acc_t'($signed(coefs.exe)) * acc_t'(exe_t);
        total    = term_ofs + term_cur + term_nbr + term_exe;
        scaled   = total >>> COEF_FRAC;
        view.pred      = clamp_temp(scaled);
        view.pred_heat = heat_of(view.pred, HOT_T, CRIT_T);
        view.cur_heat  = heat_of(cur_t, HOT_T, CRIT_T);
    end

endmodule

// File: rtl/td_pick_coolest.sv
module td_pick_coolest
    import tdisp_pkg::*;
#(
    parameter int NUM   = 8,
    parameter int IDX_W = 3
) (
    input  logic [NUM-1:0]   elig,
    input  temp_t            pred [NUM],
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    temp_t best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NUM; i++) begin
            if (elig[i] && (!found || pred[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = pred[i];
            end
        end
    end

endmodule

// File: rtl/td_freq_step.sv
module td_freq_step #(
    parameter int LEVELS = 8,
    parameter int LVL_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_eval,
    input  logic             epoch_tick,
    output logic             dec_pulse,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS - 1);

    logic spent;
    logic fire;

    assign fire = fail_eval && !spent && (level != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            level     <= TOP;
            dec_pulse <= 1'b0;
            spent     <= 1'b0;
        end else begin
            dec_pulse <= fire;
            if (fire)
                level <= level - LVL_W'(1);
            spent <= epoch_tick ? 1'b0 : (spent | fire);
        end
    end

    // R8: each request pulse coincides with a one-step drop
    a_r8_step_drop: assert property (@(posedge clk) disable iff (rst)
        dec_pulse |-> (level == $past(level) - LVL_W'(1)));

    // R11: the level only moves together with a request pulse
    a_r11_level_hold: assert property (@(posedge clk) disable iff (rst)
        !dec_pulse |-> $stable(level));

endmodule

// File: rtl/thermal_dispatch.sv
module thermal_dispatch
    import tdisp_pkg::*;
#(
    parameter int NUM_CORES     = 8,
    parameter int SAMPLE_PERIOD = 925,
    parameter int HOT_LIMIT     = 60,
    parameter int CRIT_LIMIT    = 80,
    parameter int FREQ_LEVELS   = 8,
    localparam int IDX_W  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int FREQ_W = (FREQ_LEVELS > 1) ? $clog2(FREQ_LEVELS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        coef_we,
    input  logic [1:0]                  coef_sel,
    input  logic [COEF_W-1:0]           coef_wdata,
    input  logic [NUM_CORES*TEMP_W-1:0] core_temp,
    input  logic [NUM_CORES*TEMP_W-1:0] nbr_temp,
    input  logic [NUM_CORES*EXEC_W-1:0] wg_exec,
    input  logic [NUM_CORES-1:0]        core_busy,
    input  logic                        wg_valid,
    output logic                        wg_grant,
    output logic [IDX_W-1:0]            grant_core,
    output logic                        freq_dec,
    output logic [FREQ_W-1:0]           freq_level
);
    logic             tick;
    coef_set_t        coefs;
    temp_t            snap_cur [NUM_CORES];
    temp_t            snap_nbr [NUM_CORES];
    core_view_t       views    [NUM_CORES];
    temp_t            preds    [NUM_CORES];
    logic [NUM_CORES-1:0] elig;
    logic [NUM_CORES-1:0] cur_crit;
    logic             found;
    logic [IDX_W-1:0] pick_idx;
    logic             eval;
    logic             emergency;

    td_epoch_timer #(.PERIOD(SAMPLE_PERIOD)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    td_coef_bank u_coefs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coef_we),
        .wr_sel  (coef_sel),
        .wr_data (coef_t'(coef_wdata)),
        .coefs   (coefs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                snap_cur[i] <= '0;
                snap_nbr[i] <= '0;
            end
        end else if (tick) begin
            for (int i = 0; i < NUM_CORES; i++) begin
                snap_cur[i] <= core_temp[i*TEMP_W +: TEMP_W];
                snap_nbr[i] <= nbr_temp[i*TEMP_W +: TEMP_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        td_core_predict #(
            .HOT_LIMIT  (HOT_LIMIT),
            .CRIT_LIMIT (CRIT_LIMIT)
        ) u_pred (
            .coefs (coefs),
            .cur_t (snap_cur[g]),
            .nbr_t (snap_nbr[g]),
            .exe_t (wg_exec[g*EXEC_W +: EXEC_W]),
            .view  (views[g])
        );
        assign preds[g]    = views[g].pred;
        assign cur_crit[g] = (views[g].cur_heat == HEAT_CRIT);
        assign elig[g]     = (views[g].pred_heat == HEAT_NORMAL)
                             && !cur_crit[g] && !core_busy[g];
    end

    td_pick_coolest #(.NUM(NUM_CORES), .IDX_W(IDX_W)) u_pick (
        .elig  (elig),
        .pred  (preds),
        .found (found),
        .idx   (pick_idx)
    );

    assign eval      = wg_valid && !wg_grant;
    assign emergency = |cur_crit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wg_grant   <= 1'b0;
            grant_core <= '0;
        end else begin
            wg_grant <= eval && found;
            if (eval && found)
                grant_core <= pick_idx;
        end
    end

    td_freq_step #(.LEVELS(FREQ_LEVELS), .LVL_W(FREQ_W)) u_freq (
        .clk        (clk),
        .rst        (rst),
        .fail_eval  (eval && !found && emergency),
        .epoch_tick (tick),
        .dec_pulse  (freq_dec),
        .level      (freq_level)
    );

    // R6: a grant answers a request seen on the previous edge
    a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
        wg_grant |-> $past(wg_valid));

    // R6: grants never come back to back
    a_r6_grant_single: assert property (@(posedge clk) disable iff (rst)
        wg_grant |=> !wg_grant);

    // R8: a frequency request replaces a grant, never joins it
    a_r8_grant_xor_step: assert property (@(posedge clk) disable iff (rst)
        !(wg_grant && freq_dec));

endmodule

// File: tb/thermal_dispatch_tb.sv
module thermal_dispatch_tb;
    localparam int NC  = 8;
    localparam int P   = 16;
    localparam int HOT = 60;
    localparam int CRT = 80;
    localparam int LVL = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            coef_we = 1'b0;
    logic [1:0]      coef_sel = '0;
    logic [11:0]     coef_wdata = '0;
    logic [NC*8-1:0] core_temp = '0;
    logic [NC*8-1:0] nbr_temp = '0;
    logic [NC*8-1:0] wg_exec = '0;
    logic [NC-1:0]   core_busy = '0;
    logic            wg_valid = 1'b0;
    logic            wg_grant;
    logic [2:0]      grant_core;
    logic            freq_dec;
    logic [2:0]      freq_level;

    thermal_dispatch #(.NUM_CORES(NC), .SAMPLE_PERIOD(P)) u_dut (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_sel(coef_sel),
        .coef_wdata(coef_wdata), .core_temp(core_temp), .nbr_temp(nbr_temp),
        .wg_exec(wg_exec), .core_busy(core_busy), .wg_valid(wg_valid),
        .wg_grant(wg_grant), .grant_core(grant_core), .freq_dec(freq_dec),
        .freq_level(freq_level)
    );

    always #5 clk = ~clk;

    int    compared = 0;
    int    mismatched = 0;
    int    cycles = 0;
    string phase = "R1 reset";
    bit    done = 0;

    // reference model state
    int m_cnt, m_level, m_spent;
    int m_a [4];
    int m_snc [NC];
    int m_snn [NC];
    int e_grant, e_core, e_dec;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_level = LVL - 1; m_spent = 0;
            m_a[0] = 0; m_a[1] = 64; m_a[2] = 0; m_a[3] = 0;
            for (int i = 0; i < NC; i++) begin m_snc[i] = 0; m_snn[i] = 0; end
            e_grant = 0; e_core = 0; e_dec = 0;
        end else begin
            int best, bestv, emerg, ev, ng, fire;
            best = -1; bestv = 0; emerg = 0;
            for (int i = 0; i < NC; i++) begin
                int s, p;
                s = m_a[0] + m_a[1]*m_snc[i] + m_a[2]*m_snn[i]
                    + m_a[3]*int'(wg_exec[i*8 +: 8]);
                p = s >>> 6;
                if (p < 0) p = 0;
                if (p > 255) p = 255;
                if (m_snc[i] > CRT) emerg = 1;
                if (p < HOT && m_snc[i] <= CRT && !core_busy[i]
                    && (best < 0 || p < bestv)) begin
                    best = i; bestv = p;
                end
            end
            ev   = (wg_valid && !e_grant) ? 1 : 0;
            ng   = (ev && best >= 0) ? 1 : 0;
            if (ng) e_core = best;
            fire = (ev && best < 0 && emerg && !m_spent && m_level > 0) ? 1 : 0;
            e_dec = fire;
            if (fire) m_level = m_level - 1;
            m_spent = (m_cnt == P-1) ? 0 : (m_spent | fire);
            if (coef_we) m_a[coef_sel] = $signed(coef_wdata);
            if (m_cnt == P-1) begin
                for (int i = 0; i < NC; i++) begin
                    m_snc[i] = int'(core_temp[i*8 +: 8]);
                    m_snn[i] = int'(nbr_temp[i*8 +: 8]);
                end
                m_cnt = 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
            e_grant = ng;
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(phase, "wg_grant (R6)", int'(wg_grant), e_grant);
            if (e_grant != 0) chk(phase, "grant_core (R4)", int'(grant_core), e_core);
            chk(phase, "freq_dec (R8)", int'(freq_dec), e_dec);
            chk(phase, "freq_level (R11)", int'(freq_level), m_level);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_t(int i, int v);
        core_temp[i*8 +: 8] = 8'(v);
    endtask

    task automatic wcoef(int sel, int v);
        coef_we = 1'b1; coef_sel = 2'(sel); coef_wdata = 12'(v);
        step(1);
        coef_we = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1; wg_valid = 1'b0; core_busy = '0;
        step(2);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset values seen at the ports
        chk("R1", "wg_grant", int'(wg_grant), 0);
        chk("R1", "freq_dec", int'(freq_dec), 0);
        chk("R1", "freq_level", int'(freq_level), LVL - 1);
        rst = 1'b0;

        // R4 tie: every snapshot is 0, default weights, lowest index wins
        phase = "R4 tie";
        wg_valid = 1'b1;
        step(1);
        chk("R4", "tie grant", int'(wg_grant), 1);
        chk("R4", "tie core", int'(grant_core), 0);
        wg_valid = 1'b0;

        // R3/R5/R7/R8: edge temperatures, emergency from cores 4..7
        phase = "R3 R7 edges";
        set_t(0, 59); set_t(1, 60); set_t(2, 80); set_t(3, 81);
        for (int i = 4; i < NC; i++) set_t(i, 100);
        wg_valid = 1'b1;
        step(P + 2);
        phase = "R5 busy exclusion";
        core_busy = 8'h01;
        step(6);
        core_busy = '0;
        wg_valid = 1'b0;

        // R2: non-trivial weights and saturation
        phase = "R2 weights";
        for (int i = 0; i < NC; i++) begin
            set_t(i, 10 + 9*i);
            nbr_temp[i*8 +: 8] = 8'(70 - 5*i);
            wg_exec[i*8 +: 8]  = 8'(3*i + 1);
        end
        wcoef(0, 320); wcoef(1, 32); wcoef(2, 16); wcoef(3, -32);
        step(P + 1);
        wg_valid = 1'b1;
        step(8);
        phase = "R2 floor saturation";
        wcoef(0, -2000);
        step(4);
        phase = "R2 ceiling saturation";
        wcoef(0, 2000); wcoef(1, 2000);
        step(4);
        wg_valid = 1'b0;

        // R9: uniformly hot, no critical core: wait without steps
        do_reset;
        phase = "R9 hot wait";
        for (int i = 0; i < NC; i++) set_t(i, 70);
        step(P + 1);
        wg_valid = 1'b1;
        step(2*P);
        chk("R9", "level unchanged", int'(freq_level), LVL - 1);

        // R10/R11: emergency until the level floor
        phase = "R10 R11 stepdown";
        set_t(2, 90);
        step(P*(LVL + 2));
        chk("R11", "level floor", int'(freq_level), 0);
        wg_valid = 1'b0;

        // R7: mid-epoch changes are ignored, then random traffic
        do_reset;
        phase = "R7 random";
        for (int c = 0; c < 600; c++) begin
            wg_valid  = ($urandom_range(3) != 0);
            core_busy = 8'($urandom);
            for (int i = 0; i < NC; i++) wg_exec[i*8 +: 8] = 8'($urandom_range(40));
            if (c % 7 == 0)
                for (int i = 0; i < NC; i++) begin
                    set_t(i, $urandom_range(110));
                    nbr_temp[i*8 +: 8] = 8'($urandom_range(110));
                end
            if (c % 53 == 0) begin
                coef_we = 1'b1; coef_sel = 2'($urandom_range(3));
                coef_wdata = 12'($urandom_range(100) - 30);
            end else begin
                coef_we = 1'b0;
            end
            step(1);
        end
        coef_we = 1'b0; wg_valid = 1'b0;
        step(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule